// File: doc/BRIEF.md
# Pipelined Eight-Channel Converter Serial Port

This block is the digital serial front of an eight-channel, 12-bit sampling converter. A host frames each transfer with an active-low chip select and a serial clock that idles high. During the frame the host sends a channel address on the serial input and reads a conversion result on the serial output. The analog side is represented by a parallel bus carrying one 12-bit sample per channel.

The port is pipelined by one frame. The address a frame delivers goes into a control register and selects the channel for the next frame. The data shifted out in the current frame belongs to the channel the control register held when the frame opened. Serial input is taken on rising serial-clock edges and serial output moves on falling edges. The serial pins are oversampled by the block clock, so the serial clock must run several block-clock cycles per phase.

Top module: `adc_sio_top`

## Requirements
- R1: The address is three bits. The input bit sampled on the 3rd rising serial-clock edge of a frame is address bit 2, the 4th is bit 1, and the 5th is bit 0. Address value n selects channel n, which is samples_i bits [12n+11:12n].
- R2: Input bits sampled on rising edges 1, 2 and 6 through 16 of a frame have no effect on any later output.
- R3: The data shifted out in a frame belongs to the channel addressed by the last completed frame.
- R4: While a frame is in progress, dout_o changes only after a falling serial-clock edge and never across a rising edge.
- R5: The output word is 16 bits long: output index 0 is driven when chip select falls and index k after the k-th falling edge. Indices 0 to 3 are zero and indices 4 to 15 carry sample bits 11 down to 0. After the 16th falling edge the output is zero.
- R6: dout_en_o is low while cs_ni is high and high through an open frame.
- R7: The control register takes the new address only at the 16th rising edge of a frame. If chip select rises before that edge, the frame is dropped and the control register keeps its old value.
- R8: After reset the control register is zero, dout_o and dout_en_o are low, and the first frame carries channel 0.
- R9: The selected sample is latched when chip select falls. Changes on samples_i later in the frame do not alter the word being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial address input |
| samples_i | input | 96 | Eight 12-bit channel samples, channel 0 in the low bits |
| dout_o | output | 1 | Serial result output |
| dout_en_o | output | 1 | Output drive enable (high-impedance when low) |

## Verification
The assertions assume that the serial clock idles high and that each of its phases lasts at least two block-clock cycles, so every edge shows up as a single one-cycle event. They also assume that chip select changes only while the serial clock is high. The bench drives every serial pin on the falling edge of the block clock and holds each serial phase for four block-clock cycles. It lowers and raises chip select only while the serial clock is high and leaves at least four block-clock cycles between frames. Because of this, the edge-relative properties on dout_o and on the control register see clean, well-separated events.

// File: rtl/adc_sio_pkg.sv
package adc_sio_pkg;
  localparam int unsigned NUM_CH     = 8;
  localparam int unsigned SMP_W      = 12;
  localparam int unsigned FRAME_LEN  = 16;
  localparam int unsigned ADDR_FIRST = 3;  // rise index carrying the address MSB
endpackage

// File: rtl/adc_sio_edge.sv
module adc_sio_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_fall_o,
  output logic active_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
      active_o <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (cs_ni)          active_o <= 1'b0;
      else if (cs_fall_o) active_o <= 1'b1;
    end
  end

  assign rise_o    = sclk_i & ~sclk_q;
  assign fall_o    = ~sclk_i & sclk_q;
  assign cs_fall_o = cs_q & ~cs_ni;
endmodule

// File: rtl/adc_sio_ctrl.sv
module adc_sio_ctrl #(
  parameter int unsigned FRAME_LEN  = 16,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ADDR_FIRST = 3,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_fall_i,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              din_i,
  output logic [ADDR_W-1:0] ctrl_o
);
  logic [CNT_W-1:0]  rise_cnt;
  logic [CNT_W-1:0]  nth;
  logic [ADDR_W-1:0] pend;
  logic              step;

  assign nth  = rise_cnt + CNT_W'(1);
  assign step = rise_i && active_i && !cs_ni && (rise_cnt < CNT_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0;
      pend     <= '0;
      ctrl_o   <= '0;
    end else if (cs_fall_i) begin
      rise_cnt <= '0;
    end else if (step) begin
      rise_cnt <= nth;
      for (int b = 0; b < int'(ADDR_W); b++)
        if (nth == CNT_W'(ADDR_FIRST + ADDR_W - 1 - b)) pend[b] <= din_i;
      // commit only when the frame is complete; an earlier cs rise drops it
      if (nth == CNT_W'(FRAME_LEN)) ctrl_o <= pend;
    end
  end
endmodule

// File: rtl/adc_sio_shift.sv
module adc_sio_shift #(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned SMP_W     = 12,
  parameter int unsigned FRAME_LEN = 16,
  localparam int unsigned ADDR_W   = $clog2(NUM_CH),
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1),
  localparam int unsigned LEAD     = FRAME_LEN - SMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_fall_i,
  input  logic                    active_i,
  input  logic                    fall_i,
  input  logic [ADDR_W-1:0]       ctrl_i,
  input  logic [NUM_CH*SMP_W-1:0] samples_i,
  output logic                    dout_o,
  output logic [CNT_W-1:0]        fall_cnt_o
);
  logic [SMP_W-1:0]     ch_smp [NUM_CH];
  logic [FRAME_LEN-1:0] sreg;

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    assign ch_smp[g] = samples_i[g*SMP_W +: SMP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg       <= '0;
      fall_cnt_o <= '0;
    end else if (cs_fall_i) begin
      sreg       <= {{LEAD{1'b0}}, ch_smp[ctrl_i]};
      fall_cnt_o <= '0;
    end else if (fall_i && active_i) begin
      sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
      if (fall_cnt_o < CNT_W'(FRAME_LEN)) fall_cnt_o <= fall_cnt_o + CNT_W'(1);
    end
  end

  assign dout_o = sreg[FRAME_LEN-1];
endmodule

// File: rtl/adc_sio_top.sv
module adc_sio_top
  import adc_sio_pkg::*;
#(
  parameter int unsigned CH       = NUM_CH,
  parameter int unsigned SW       = SMP_W,
  parameter int unsigned FLEN     = FRAME_LEN,
  parameter int unsigned AFIRST   = ADDR_FIRST,
  localparam int unsigned AW      = $clog2(CH),
  localparam int unsigned CW      = $clog2(FLEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic [CH*SW-1:0] samples_i,
  output logic             dout_o,
  output logic             dout_en_o
);
  logic          rise, fall, cs_fall, active;
  logic [AW-1:0] ctrl_q;
  logic [CW-1:0] fall_cnt;

  adc_sio_edge u_edge (
    .clk_i, .rst_ni, .cs_ni, .sclk_i,
    .rise_o(rise), .fall_o(fall), .cs_fall_o(cs_fall), .active_o(active)
  );

  adc_sio_ctrl #(.FRAME_LEN(FLEN), .ADDR_W(AW), .ADDR_FIRST(AFIRST)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni,
    .cs_fall_i(cs_fall), .active_i(active), .rise_i(rise), .din_i,
    .ctrl_o(ctrl_q)
  );

  adc_sio_shift #(.NUM_CH(CH), .SMP_W(SW), .FRAME_LEN(FLEN)) u_shift (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .active_i(active), .fall_i(fall),
    .ctrl_i(ctrl_q), .samples_i,
    .dout_o, .fall_cnt_o(fall_cnt)
  );

  assign dout_en_o = active;
endmodule

// File: rtl/adc_sio_chk.sv
module adc_sio_chk #(
  parameter int unsigned AW   = 3,
  parameter int unsigned CW   = 5,
  parameter int unsigned LEAD = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          sclk_i,
  input logic          dout_o,
  input logic          dout_en_o,
  input logic [AW-1:0] ctrl_q,
  input logic [CW-1:0] fall_cnt
);
  p_idle_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) |-> !dout_en_o);

  p_hold_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni && !$past(cs_ni) && $past(dout_en_o) |-> dout_en_o);

  p_dout_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o && $past(dout_en_o) && (dout_o != $past(dout_o))
      |-> !$past(sclk_i) && $past(sclk_i, 2));

  p_ctrl_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q != $past(ctrl_q) |-> $past(sclk_i) && !$past(sclk_i, 2) && !$past(cs_ni));

  p_lead_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o && (fall_cnt < CW'(LEAD)) |-> !dout_o);
endmodule

bind adc_sio_top adc_sio_chk #(.AW(AW), .CW(CW), .LEAD(FLEN - SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
  .dout_o(dout_o), .dout_en_o(dout_en_o), .ctrl_q(ctrl_q), .fall_cnt(fall_cnt)
);

// File: tb/tb_adc_sio_top.sv
module tb_adc_sio_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b1;
  logic        din_i = 1'b0;
  logic [95:0] samples_i;
  logic        dout_o, dout_en_o;
  logic [11:0] samp [8];
  logic [2:0]  model_ctrl = 3'd0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb
    for (int c = 0; c < 8; c++) samples_i[c*12 +: 12] = samp[c];

  adc_sio_top dut (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .din_i,
    .samples_i, .dout_o, .dout_en_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_samples(input int seed);
    for (int c = 0; c < 8; c++) samp[c] = 12'((c + 1) * 273 + seed * 97) ^ 12'hA5C;
  endtask

  task automatic run_frame(input logic [2:0] addr, input logic [15:0] junk,
                           input int rises, input bit flip);
    logic [15:0] word;
    logic [11:0] exp_s;
    logic        b;
    bit          stab_ok;
    exp_s   = samp[model_ctrl];
    stab_ok = 1'b1;
    word    = '0;
    cs_ni   = 1'b0;
    wclk(4);
    word[15] = dout_o;
    chk(dout_en_o == 1'b1, "R6 en in frame", 32'(dout_en_o), 32'd1);
    for (int k = 1; k <= rises; k++) begin
      sclk_i = 1'b0;
      din_i  = (k == 3) ? addr[2] : (k == 4) ? addr[1] : (k == 5) ? addr[0] : junk[k-1];
      wclk(2);
      b = dout_o;
      if (k <= 15) word[15-k] = dout_o;
      else chk(dout_o == 1'b0, "R5 tail zero", 32'(dout_o), 32'd0);
      if (flip && k == 2) set_samples(77);  // R9: bus changes mid-frame
      wclk(2);
      sclk_i = 1'b1;
      wclk(3);
      if (dout_o != b) stab_ok = 1'b0;
      wclk(1);
    end
    cs_ni = 1'b1;
    wclk(4);
    chk(dout_en_o == 1'b0, "R6 en idle", 32'(dout_en_o), 32'd0);
    if (rises == 16) begin
      chk(word == {4'b0, exp_s}, "R1 R2 R3 R5 R9 word", 32'(word), 32'({4'b0, exp_s}));
      chk(stab_ok, "R4 stable across rise", 32'(stab_ok), 32'd1);
      model_ctrl = addr;
    end else begin
      // R7: dropped frame, partial bits still follow the format
      chk(word[15:12] == 4'b0, "R7 R5 partial lead", 32'(word[15:12]), 32'd0);
    end
  endtask

  initial begin
    set_samples(0);
    wclk(3);
    chk(dout_o == 1'b0 && dout_en_o == 1'b0, "R8 reset outputs",
        32'({dout_o, dout_en_o}), 32'd0);
    rst_ni = 1'b1;
    wclk(4);
    // R8: first frame must carry channel 0
    run_frame(3'd5, 16'hFFFF, 16, 1'b0);
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 8; a++) begin
        logic [15:0] jk;
        jk = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0000 : 16'(a * 16'h9D3 + 16'h1357);
        set_samples(p * 8 + a);
        run_frame(3'((a * 5 + p + 1) % 8), jk, 16, 1'b0);
      end
    end
    // R7: aborts after address fully loaded and mid-address
    run_frame(3'd6, 16'hAAAA, 10, 1'b0);
    run_frame(3'd1, 16'h5555, 4, 1'b0);
    run_frame(3'd2, 16'h0F0F, 16, 1'b0);
    run_frame(3'd7, 16'hF0F0, 16, 1'b0);
    // R9
    set_samples(5);
    run_frame(3'd4, 16'h3C3C, 16, 1'b1);
    run_frame(3'd0, 16'hC3C3, 16, 1'b0);
    run_frame(3'd0, 16'h0000, 16, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule